// File: doc/BRIEF.md
# Column Command Decoder with Burst Interrupt Check

This block sits on the command/address side of a low-power DDR memory controller or PHY monitor. Each clock it receives two samples of the ten-bit command/address bus, one taken on the rising edge and one on the falling edge, plus the chip select. It picks out column access commands (READ or WRITE) and rebuilds their starting column address from the two samples. Every other command type is ignored.

A small tracker follows the burst started by the last accepted column command. Its length comes from the burst-length setting sampled with that command, and it advances two data beats per clock. A new column command that lands while a burst is still running is an interruption. The block checks it against the rules for the active burst length, the 4-beat boundary grid and a programmable minimum command spacing. A legal command is reported and restarts the tracker. An illegal one raises a one-cycle flag and leaves the tracker untouched.

All outputs are registered, so a command sampled at a rising edge shows its result in the following cycle.

Top module: `col_cmd_decoder`

## Requirements
- R1: A column command is recognised only when `cs_ni` is 0, `ca_rise_i[0]` is 1 and `ca_rise_i[1]` is 0 at the rising edge. Any other pattern, including any pattern with `cs_ni` at 1, leaves `cmd_valid_o` and `illegal_o` at 0 in the next cycle.
- R2: For an accepted command, `cmd_rd_o` in the next cycle equals the sampled `ca_rise_i[2]`, where 1 means READ and 0 means WRITE.
- R3: For an accepted command, `col_addr_o` in the next cycle equals `{ca_fall_i[9:1], ca_rise_i[6:5]}`, with the falling-edge bits in positions 10:2 and the rising-edge bits in positions 1:0.
- R4: `bl_cfg_i` is sampled with each accepted command: 2'b01 means BL4, 2'b10 means BL8, 2'b11 means BL16, and 2'b00 is treated as BL4. `burst_active_o` rises in the cycle `cmd_valid_o` pulses and stays high for BL/2-1 cycles in total.
- R5: If the active burst is BL4, a column command sampled while `burst_active_o` is 1 is illegal.
- R6: If the active burst is BL8 or BL16, a column command sampled while `burst_active_o` is 1 and whose direction differs from the active burst is illegal.
- R7: A same-direction command sampled while `burst_active_o` is 1 at an odd number of cycles after the last accepted command is illegal, because it misses a 4-beat boundary.
- R8: A command sampled while `burst_active_o` is 1 at fewer than `tccd_i` cycles after the last accepted command is illegal.
- R9: A same-direction command during a BL8/BL16 burst, at an even distance of at least `tccd_i` cycles, is accepted and restarts the burst with the newly sampled burst length.
- R10: An illegal command pulses `illegal_o` for one cycle, does not pulse `cmd_valid_o`, and does not restart the tracker, so `burst_active_o` ends on the schedule of the original burst.
- R11: A column command sampled while `burst_active_o` is 0 is always accepted, whatever `tccd_i` is.
- R12: While `rst_ni` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ca_rise_i | input | 10 | Command/address sample from the rising edge |
| ca_fall_i | input | 10 | Command/address sample from the falling edge |
| bl_cfg_i | input | 2 | Burst length setting |
| tccd_i | input | 4 | Minimum cycles between column commands for an interruption |
| cmd_valid_o | output | 1 | One-cycle pulse for an accepted column command |
| cmd_rd_o | output | 1 | Direction of the last accepted command, 1 = READ |
| col_addr_o | output | 11 | Starting column address of the last accepted command |
| burst_active_o | output | 1 | A burst is in progress |
| illegal_o | output | 1 | One-cycle pulse for a rejected interruption |

## Verification
The most delicate case is the ending of a burst colliding with a new command in the same cycle. A command sampled on the last cycle in which `burst_active_o` is high is judged as an interruption, while one sampled a cycle later is a fresh burst. The bench places commands exactly on both sides of this edge, at odd and even distances and with a large `tccd_i`. A reference model, driven by the cycle distance since the last accepted command, predicts `cmd_valid_o`, `illegal_o` and `burst_active_o` for every cycle. The model also covers restart versus no restart, so a wrongly accepted interruption shows up as a shifted burst end.

// File: rtl/col_cmd_pkg.sv
`timescale 1ns/1ps
package col_cmd_pkg;

  typedef enum logic [1:0] {
    BL_RSV = 2'b00,
    BL_4   = 2'b01,
    BL_8   = 2'b10,
    BL_16  = 2'b11
  } bl_cfg_e;

  // opcode / field positions inside the rising-edge sample
  localparam int unsigned OP_ACT_BIT = 0;
  localparam int unsigned OP_NEG_BIT = 1;
  localparam int unsigned OP_DIR_BIT = 2;
  localparam int unsigned RISE_COL_LO = 5;
  localparam int unsigned RISE_COL_HI = 6;

  // clock cycles a burst occupies: two beats per cycle
  function automatic int unsigned half_cycles(logic [1:0] cfg);
    case (bl_cfg_e'(cfg))
      BL_8:    return 4;
      BL_16:   return 8;
      default: return 2;
    endcase
  endfunction

  function automatic logic is_short(logic [1:0] cfg);
    return !(cfg == BL_8 || cfg == BL_16);
  endfunction

endpackage

// File: rtl/col_cmd_decode.sv
`timescale 1ns/1ps
module col_cmd_decode
  import col_cmd_pkg::*;
#(
  parameter int unsigned CA_W  = 10,
  parameter int unsigned COL_W = CA_W + 1
) (
  input  logic             cs_ni,
  input  logic [CA_W-1:0]  ca_rise_i,
  input  logic [CA_W-1:0]  ca_fall_i,
  output logic             col_cmd_o,
  output logic             rd_o,
  output logic [COL_W-1:0] col_o
);

  logic unused_bits;

  assign col_cmd_o = !cs_ni && ca_rise_i[OP_ACT_BIT] && !ca_rise_i[OP_NEG_BIT];
  assign rd_o      = ca_rise_i[OP_DIR_BIT];
  assign col_o     = {ca_fall_i[CA_W-1:1], ca_rise_i[RISE_COL_HI:RISE_COL_LO]};

  assign unused_bits = ^{ca_fall_i[0], ca_rise_i[CA_W-1:RISE_COL_HI+1],
                         ca_rise_i[RISE_COL_LO-1:OP_DIR_BIT+1]};

endmodule

// File: rtl/col_burst_tracker.sv
`timescale 1ns/1ps
module col_burst_tracker
  import col_cmd_pkg::*;
#(
  parameter int unsigned AGE_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_rd_i,
  input  logic [1:0]       start_cfg_i,
  output logic             busy_o,
  output logic [AGE_W-1:0] age_o,
  output logic             rd_o,
  output logic             short_o
);

  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] half_q;
  logic [AGE_W:0]   age_inc;

  assign age_inc = {1'b0, age_o} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      age_o   <= '0;
      rd_o    <= 1'b0;
      short_o <= 1'b1;
      half_q  <= '0;
    end else if (start_i) begin
      busy_o  <= 1'b1;
      age_o   <= AGE_W'(1);
      rd_o    <= start_rd_i;
      short_o <= is_short(start_cfg_i);
      half_q  <= AGE_W'(half_cycles(start_cfg_i));
    end else begin
      // age saturates; busy drops once the next edge reaches the burst end
      if (age_o != AGE_MAX) age_o <= age_inc[AGE_W-1:0];
      busy_o <= busy_o && (age_inc < {1'b0, half_q});
    end
  end

  a_r4_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && age_o == AGE_W'(1));

  a_r10_age_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && age_o != AGE_MAX) |=> age_o == $past(age_o) + 1'b1);

  a_r10_busy_no_revive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !busy_o) |=> !busy_o);

endmodule

// File: rtl/col_interrupt_check.sv
`timescale 1ns/1ps
module col_interrupt_check #(
  parameter int unsigned AGE_W  = 5,
  parameter int unsigned TCCD_W = 4
) (
  input  logic              busy_i,
  input  logic              short_i,
  input  logic              cur_rd_i,
  input  logic              new_rd_i,
  input  logic [AGE_W-1:0]  age_i,
  input  logic [TCCD_W-1:0] tccd_i,
  output logic              legal_o
);

  localparam int unsigned CMP_W = (AGE_W > TCCD_W) ? AGE_W : TCCD_W;

  logic [CMP_W-1:0] age_x, tccd_x;
  logic             same_dir, on_grid, spaced;

  assign age_x    = CMP_W'(age_i);
  assign tccd_x   = CMP_W'(tccd_i);
  assign same_dir = (cur_rd_i == new_rd_i);
  assign on_grid  = !age_i[0];
  assign spaced   = (age_x >= tccd_x);

  assign legal_o = !busy_i || (!short_i && same_dir && on_grid && spaced);

endmodule

// File: rtl/col_cmd_decoder.sv
`timescale 1ns/1ps
module col_cmd_decoder
  import col_cmd_pkg::*;
#(
  parameter int unsigned CA_W   = 10,
  parameter int unsigned TCCD_W = 4,
  parameter int unsigned AGE_W  = 5,
  localparam int unsigned COL_W = CA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [CA_W-1:0]   ca_rise_i,
  input  logic [CA_W-1:0]   ca_fall_i,
  input  logic [1:0]        bl_cfg_i,
  input  logic [TCCD_W-1:0] tccd_i,
  output logic              cmd_valid_o,
  output logic              cmd_rd_o,
  output logic [COL_W-1:0]  col_addr_o,
  output logic              burst_active_o,
  output logic              illegal_o
);

  logic             col_cmd, new_rd, legal, accept, reject;
  logic [COL_W-1:0] new_col;
  logic             trk_busy, trk_rd, trk_short;
  logic [AGE_W-1:0] trk_age;

  col_cmd_decode #(.CA_W(CA_W), .COL_W(COL_W)) u_decode (
    .cs_ni     (cs_ni),
    .ca_rise_i (ca_rise_i),
    .ca_fall_i (ca_fall_i),
    .col_cmd_o (col_cmd),
    .rd_o      (new_rd),
    .col_o     (new_col)
  );

  col_interrupt_check #(.AGE_W(AGE_W), .TCCD_W(TCCD_W)) u_check (
    .busy_i   (trk_busy),
    .short_i  (trk_short),
    .cur_rd_i (trk_rd),
    .new_rd_i (new_rd),
    .age_i    (trk_age),
    .tccd_i   (tccd_i),
    .legal_o  (legal)
  );

  assign accept = col_cmd && legal;
  assign reject = col_cmd && !legal;

  col_burst_tracker #(.AGE_W(AGE_W)) u_tracker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .start_rd_i  (new_rd),
    .start_cfg_i (bl_cfg_i),
    .busy_o      (trk_busy),
    .age_o       (trk_age),
    .rd_o        (trk_rd),
    .short_o     (trk_short)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      illegal_o   <= 1'b0;
      cmd_rd_o    <= 1'b0;
      col_addr_o  <= '0;
    end else begin
      cmd_valid_o <= accept;
      illegal_o   <= reject;
      if (accept) begin
        cmd_rd_o   <= new_rd;
        col_addr_o <= new_col;
      end
    end
  end

  assign burst_active_o = trk_busy;

  a_r1_deselect_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !cmd_valid_o && !illegal_o);

  a_r2_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> cmd_valid_o && cmd_rd_o == $past(ca_rise_i[OP_DIR_BIT]));

  a_r3_column: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> col_addr_o == $past({ca_fall_i[CA_W-1:1], ca_rise_i[RISE_COL_HI:RISE_COL_LO]}));

  a_r5_short_no_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_cmd && trk_busy && trk_short) |=> illegal_o && !cmd_valid_o);

  a_r6_dir_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_cmd && trk_busy && trk_rd != new_rd) |=> illegal_o);

  a_r7_odd_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_cmd && trk_busy && trk_age[0]) |=> illegal_o);

  a_r11_idle_accepts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_cmd && !trk_busy) |=> cmd_valid_o && !illegal_o);

  a_r10_single_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !cmd_valid_o);

endmodule

// File: tb/col_cmd_decoder_bench.sv
`timescale 1ns/1ps
module col_cmd_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic [9:0]  ca_rise = '0;
  logic [9:0]  ca_fall = '0;
  logic [1:0]  bl_cfg = 2'b01;
  logic [3:0]  tccd = 4'd2;
  logic        cmd_valid, cmd_rd, burst_active, illegal;
  logic [10:0] col_addr;

  always #10 clk = ~clk;

  col_cmd_decoder u_col_cmd_decoder (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .cs_ni          (cs_ni),
    .ca_rise_i      (ca_rise),
    .ca_fall_i      (ca_fall),
    .bl_cfg_i       (bl_cfg),
    .tccd_i         (tccd),
    .cmd_valid_o    (cmd_valid),
    .cmd_rd_o       (cmd_rd),
    .col_addr_o     (col_addr),
    .burst_active_o (burst_active),
    .illegal_o      (illegal)
  );

  typedef struct {
    bit          vld;
    bit          ill;
    bit          rd;
    logic [10:0] col;
    bit          busy;
    string       tag;
  } exp_t;

  exp_t  sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;

  // reference state
  bit    m_have = 0;
  int    m_last = 0;
  int    m_half = 2;
  bit    m_rd = 0;
  bit    m_short = 1;
  int    cyc = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // kind: 0 deselected, 1 column command, 2 selected non-column pattern
  task automatic step(input int kind, input bit rd, input logic [10:0] col,
                      input logic [1:0] bl, input int tc, input string tag);
    exp_t e;
    int   d;
    bit   inb, legal, iscmd;
    @(negedge clk);
    cyc++;
    ca_rise       = {cyc[2:0], col[1:0], ~cyc[1:0], rd, 1'b0, 1'b1};
    if (kind == 2) ca_rise[0] = 1'b0;
    ca_fall       = {col[10:2], cyc[0]};
    cs_ni         = (kind == 0);
    bl_cfg        = bl;
    tccd          = 4'(tc);
    iscmd = (kind == 1);
    d     = cyc - m_last;
    inb   = m_have && (d < m_half);
    legal = !inb || (!m_short && rd == m_rd && (d % 2 == 0) && d >= tc);
    e.vld  = iscmd && legal;
    e.ill  = iscmd && !legal;
    e.rd   = rd;
    e.col  = col;
    e.tag  = tag;
    e.busy = e.vld ? 1'b1 : (m_have && (d + 1 < m_half));
    if (e.vld) begin
      m_have  = 1;
      m_last  = cyc;
      m_half  = (bl == 2'b10) ? 4 : (bl == 2'b11) ? 8 : 2;
      m_short = !(bl == 2'b10 || bl == 2'b11);
      m_rd    = rd;
    end
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 1'b0, 11'h000, 2'b01, 2, tag);
  endtask

  // monitor
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        chk(e.tag, "cmd_valid", int'(cmd_valid), int'(e.vld));
        chk(e.tag, "illegal", int'(illegal), int'(e.ill));
        chk(e.tag, "burst_active", int'(burst_active), int'(e.busy));
        if (e.vld) begin
          chk(e.tag, "cmd_rd", int'(cmd_rd), int'(e.rd));
          chk(e.tag, "col_addr", int'(col_addr), int'(e.col));
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    @(posedge clk);
    #5;
    // R12: reset state
    chk("R12", "cmd_valid", int'(cmd_valid), 0);
    chk("R12", "illegal", int'(illegal), 0);
    chk("R12", "burst_active", int'(burst_active), 0);
    chk("R12", "cmd_rd", int'(cmd_rd), 0);
    chk("R12", "col_addr", int'(col_addr), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1: deselected / non-column patterns produce nothing
    step(0, 1'b1, 11'h7FF, 2'b01, 2, "R1");
    step(2, 1'b1, 11'h155, 2'b01, 2, "R1");
    step(2, 1'b0, 11'h2AA, 2'b10, 2, "R1");

    // R2/R3: BL4 read, then an interruption inside it (R5)
    step(1, 1'b1, 11'h5A3, 2'b01, 2, "R3");
    step(1, 1'b1, 11'h0F0, 2'b01, 2, "R5");
    // burst over: reserved setting behaves as BL4 (R4), write direction (R2)
    step(1, 1'b0, 11'h2C4, 2'b00, 2, "R4");
    idle(1, "R4");
    step(1, 1'b1, 11'h013, 2'b01, 0, "R2");
    idle(2, "R4");

    // BL8 write, opposite direction (R6), legal restart as BL16 (R9)
    step(1, 1'b0, 11'h3C1, 2'b10, 2, "R4");
    step(1, 1'b1, 11'h111, 2'b10, 2, "R6");
    step(1, 1'b0, 11'h4E2, 2'b11, 2, "R9");
    step(1, 1'b0, 11'h222, 2'b11, 2, "R7");
    step(1, 1'b1, 11'h333, 2'b11, 2, "R6");
    step(1, 1'b0, 11'h444, 2'b11, 2, "R7");
    // R10: rejections left the BL16 burst on its own schedule
    idle(6, "R10");

    // R8: spacing rule with tccd = 4 during a BL16 read burst
    step(1, 1'b1, 11'h6B5, 2'b11, 4, "R4");
    step(0, 1'b0, 11'h000, 2'b11, 4, "R8");
    step(1, 1'b1, 11'h0AA, 2'b11, 4, "R8");
    step(0, 1'b0, 11'h000, 2'b11, 4, "R8");
    step(1, 1'b1, 11'h7E1, 2'b10, 4, "R9");
    idle(5, "R10");

    // R11: burst end edge with large tccd
    step(1, 1'b0, 11'h19C, 2'b10, 15, "R11");
    step(0, 1'b0, 11'h000, 2'b10, 15, "R11");
    step(1, 1'b0, 11'h0C3, 2'b10, 15, "R8");
    step(1, 1'b0, 11'h0C4, 2'b10, 15, "R7");
    step(1, 1'b0, 11'h2DB, 2'b01, 15, "R11");
    step(1, 1'b0, 11'h2DC, 2'b01, 15, "R5");
    step(1, 1'b1, 11'h7FF, 2'b10, 15, "R11");
    idle(4, "R11");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule